// File: doc/BRIEF.md
# Serial Controller FIFO Threshold Unit

This block is the byte buffering and event layer between a CPU register port and the byte engine of a two-wire serial controller. It holds a receive FIFO, which the engine fills and software empties through an 8-bit data register, and a transmit FIFO, which software fills and the engine drains. Each FIFO has its own programmable threshold and its own clear control. Software can therefore move data in bursts of one threshold instead of taking an interrupt per byte.

A 16-bit transfer count is loaded before a transfer and counts down once for each byte the engine moves. The count lets the block tell a full burst from a short final remainder. A ready event is raised when a whole threshold can be moved. A drain event is raised when the rest of the transfer is smaller than the threshold. When a drain event is raised, the buffer status register gives the exact number of bytes to move. The engine is modelled as push and pop strobes, and an `xfer_rx` input selects the active direction.

Events are sticky status bits that software clears by writing 1 to them. The interrupt line is the OR of the status bits whose enable bits are set.

Top module: `sfet_unit`

Register map, selected by `reg_addr`:
- 0: data register. A read pops the receive FIFO and a write pushes the transmit FIFO.
- 1: transfer count.
- 2: buffer configuration. Bits 13:8 hold the receive threshold minus one. Bits 5:0 hold the transmit threshold minus one. Bit 14 clears the receive FIFO and bit 6 clears the transmit FIFO.
- 3: buffer status.
- 4: event status.
- 5: event enable.

## Requirements
- R1: Buffer status bits 15:14 read back the depth code C, and each FIFO holds 8<<C bytes. The default is C=1, so the depth is 16.
- R2: A threshold is its configuration field plus one. Reading the configuration register returns both threshold fields, with bits 14 and 6 reading as 0.
- R3: Writing 1 to configuration bit 14 empties the receive FIFO, and writing 1 to bit 6 empties the transmit FIFO.
- R4: Writes to the data register enter the transmit FIFO and leave in order on `eng_tx_data`, one cycle after `eng_tx_pop`. Bytes pushed by the engine are returned in order by data-register reads. Every read returns its value on `reg_rdata` one cycle after `reg_rd`.
- R5: Receive-ready (event bit 3) is set while receiving when the receive fill level is at least the receive threshold.
- R6: Transmit-ready (event bit 4) is set while transmitting when the free space and the bytes still to be supplied are both at least the transmit threshold. The bytes still to be supplied are the transfer count minus the transmit fill level, floored at 0.
- R7: Receive-drain (event bit 13) is set while receiving when the count is 0 and the fill level is non-zero but below the threshold. Buffer status bits 5:0 then give that fill level.
- R8: Transmit-drain (event bit 14) is set while transmitting when the bytes still to be supplied are non-zero, below the threshold and no more than the free space. Buffer status bits 5:0 then give that number.
- R9: An event bit stays set until a write of 1 clears it. If its condition holds in the same cycle as the clear, the bit is set again.
- R10: `irq` is the OR of the event bits ANDed with the enable register, and it changes in the same cycle as the event bits.
- R11: An engine push into a full receive FIFO drops the byte and sets overrun (event bit 11).
- R12: An engine pop from an empty transmit FIFO returns 0 and sets underflow (event bit 10).
- R13: The transfer count decrements once per engine push or pop, stops at 0, and reads back through register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| xfer_rx | input | 1 | Active direction: 1 receive, 0 transmit |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Engine takes a byte to send |
| eng_tx_data | output | 8 | Byte to send, valid one cycle after `eng_tx_pop` |

## Verification
A register write or an engine strobe changes the fill level or the count at the clock edge where it is sampled. Every event bit and `irq` is then registered at the next edge, so they trail their cause by one cycle. `reg_rdata` and `eng_tx_data` are valid one cycle after their strobe. The bench drives on falling edges and lets at least two edges pass after any stimulus before reading status. It samples read data at the falling edge that follows the capturing rising edge. The sticky-clear race is exercised by clearing receive-ready while its fill condition still holds.

// File: rtl/sfet_pkg.sv
package sfet_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_XCNT = 3'd1;
  localparam logic [2:0] A_BCFG = 3'd2;
  localparam logic [2:0] A_BSTA = 3'd3;
  localparam logic [2:0] A_EVST = 3'd4;
  localparam logic [2:0] A_EVEN = 3'd5;

  localparam int EV_TXDRN = 14;
  localparam int EV_RXDRN = 13;
  localparam int EV_OVR   = 11;
  localparam int EV_UDF   = 10;
  localparam int EV_TXRDY = 4;
  localparam int EV_RXRDY = 3;
  localparam logic [15:0] EV_MASK = 16'h6C18;

  localparam int CFG_RXCLR = 14;
  localparam int CFG_TXCLR = 6;
  localparam int CFG_RXTH  = 8;
  localparam int THF_W     = 6;
endpackage

// File: rtl/sfet_fifo.sv
module sfet_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= do_pop ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  a_r11_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
endmodule

// File: rtl/sfet_events.sv
module sfet_events #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH) + 1,
  parameter int CW    = 16,
  parameter int TW    = 6
) (
  input  logic          xfer_rx,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [CW-1:0] cnt,
  input  logic [TW-1:0] rx_thf,
  input  logic [TW-1:0] tx_thf,
  output logic          rx_rdy,
  output logic          rx_drn,
  output logic          tx_rdy,
  output logic          tx_drn,
  output logic [5:0]    stat_low
);
  localparam int XW = CW + 2;

  logic [XW-1:0] rxl, txl, rxt, txt, cx, need, free;

  function automatic logic [5:0] sat6(input logic [XW-1:0] v);
    return (v > XW'(63)) ? 6'd63 : v[5:0];
  endfunction

  always_comb begin
    rxl  = XW'(rx_level);
    txl  = XW'(tx_level);
    rxt  = XW'(rx_thf) + XW'(1);
    txt  = XW'(tx_thf) + XW'(1);
    cx   = XW'(cnt);
    need = (cx > txl) ? (cx - txl) : '0;
    free = XW'(DEPTH) - txl;
    rx_rdy = xfer_rx && (rxl >= rxt);
    rx_drn = xfer_rx && (cx == '0) && (rxl != '0) && (rxl < rxt);
    tx_rdy = !xfer_rx && (free >= txt) && (need >= txt);
    tx_drn = !xfer_rx && (need != '0) && (need < txt) && (free >= need);
    stat_low = xfer_rx ? sat6(rxl) : sat6(need);
  end
endmodule

// File: rtl/sfet_unit.sv
module sfet_unit #(
  parameter int DEPTH_CODE = 1,
  parameter int DW         = 8,
  parameter int CW         = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq,
  input  logic          xfer_rx,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data
);
  import sfet_pkg::*;

  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic [THF_W-1:0] rx_thf, tx_thf;
  logic [15:0]      ev_q, ien_q, ev_clr, ev_set, ev_n, rd_q;
  logic [CW-1:0]    cnt_q;
  logic [LW-1:0]    rx_level, tx_level;
  logic [DW-1:0]    rx_rdata;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rx_clr, tx_clr, wr_data, rd_data, rd_data_q;
  logic             rx_rdy, rx_drn, tx_rdy, tx_drn;
  logic [5:0]       stat_low;

  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign rd_data = reg_rd && (reg_addr == A_DATA);
  assign rx_clr  = reg_wr && (reg_addr == A_BCFG) && reg_wdata[CFG_RXCLR];
  assign tx_clr  = reg_wr && (reg_addr == A_BCFG) && reg_wdata[CFG_TXCLR];

  sfet_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rd_data), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sfet_fifo #(.W(DW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(wr_data), .wdata(reg_wdata[DW-1:0]),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sfet_events #(.DEPTH(DEPTH), .LW(LW), .CW(CW), .TW(THF_W)) u_ev (
    .xfer_rx(xfer_rx), .rx_level(rx_level), .tx_level(tx_level),
    .cnt(cnt_q), .rx_thf(rx_thf), .tx_thf(tx_thf),
    .rx_rdy(rx_rdy), .rx_drn(rx_drn), .tx_rdy(tx_rdy), .tx_drn(tx_drn),
    .stat_low(stat_low)
  );

  // event set has priority over a same-cycle write-one clear
  always_comb begin
    ev_set = '0;
    ev_set[EV_RXRDY] = rx_rdy;
    ev_set[EV_RXDRN] = rx_drn;
    ev_set[EV_TXRDY] = tx_rdy;
    ev_set[EV_TXDRN] = tx_drn;
    ev_set[EV_OVR]   = eng_rx_push && rx_full && !rx_clr;
    ev_set[EV_UDF]   = eng_tx_pop && tx_empty;
    ev_clr = (reg_wr && (reg_addr == A_EVST)) ? reg_wdata : '0;
    ev_n   = ((ev_q & ~ev_clr) | ev_set) & EV_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      ien_q <= '0;
      irq   <= 1'b0;
    end else begin
      ev_q <= ev_n;
      irq  <= |(ev_n & ien_q);
      if (reg_wr && (reg_addr == A_EVEN)) ien_q <= reg_wdata & EV_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_thf <= '0;
      tx_thf <= '0;
    end else if (reg_wr && (reg_addr == A_BCFG)) begin
      rx_thf <= reg_wdata[CFG_RXTH +: THF_W];
      tx_thf <= reg_wdata[THF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reg_wr && (reg_addr == A_XCNT)) begin
      cnt_q <= reg_wdata[CW-1:0];
    end else if ((eng_rx_push || eng_tx_pop) && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      rd_data_q <= 1'b0;
    end else begin
      rd_data_q <= rd_data;
      if (reg_rd) begin
        unique case (reg_addr)
          A_XCNT:  rd_q <= 16'(cnt_q);
          A_BCFG:  rd_q <= {2'b00, rx_thf, 2'b00, tx_thf};
          A_BSTA:  rd_q <= {2'(DEPTH_CODE), 8'h00, stat_low};
          A_EVST:  rd_q <= ev_q;
          A_EVEN:  rd_q <= ien_q;
          default: rd_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rd_data_q ? 16'(rx_rdata) : rd_q;

  a_r9_sticky_event: assert property (@(posedge clk) disable iff (rst)
    (ev_q[EV_RXRDY] && !(reg_wr && (reg_addr == A_EVST) && reg_wdata[EV_RXRDY]))
      |=> ev_q[EV_RXRDY]);
  a_r13_count_step: assert property (@(posedge clk) disable iff (rst)
    ((eng_rx_push || eng_tx_pop) && (cnt_q != '0) && !(reg_wr && (reg_addr == A_XCNT)))
      |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r12_underflow_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_pop && tx_empty) |=> ev_q[EV_UDF]);
  a_r11_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_full && !rx_clr) |=> ev_q[EV_OVR]);
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0 && $stable(ien_q)) |=> !irq);
endmodule

// File: tb/sfet_unit_tb.sv
module sfet_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        xfer_rx = 1'b0;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sfet_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .xfer_rx(xfer_rx), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rxpush(input logic [7:0] b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic txpop(output logic [7:0] b);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
    b = eng_tx_data;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rreg(3'd3, v); chk("R1 depth code after reset", v, 16'h4000);
    rreg(3'd4, v); chk("R9 events clear after reset", v, 16'h0000);
    chk("R10 irq low after reset", 16'(irq), 16'h0000);
    wreg(3'd2, 16'h4A45);
    rreg(3'd2, v); chk("R2 threshold readback, clear bits zero", v, 16'h0A05);
  endtask

  task automatic t_rx();
    logic [15:0] v;
    xfer_rx = 1'b1;
    wreg(3'd2, 16'h4340);
    wreg(3'd4, 16'hFFFF);
    wreg(3'd1, 16'd6);
    for (int i = 0; i < 4; i++) rxpush(8'hA0 + 8'(i));
    settle();
    rreg(3'd1, v); chk("R13 count after four pushes", v, 16'd2);
    rreg(3'd4, v); chk("R5 receive ready at threshold", v, 16'h0008);
    wreg(3'd4, 16'h0008);
    settle();
    rreg(3'd4, v); chk("R9 clear loses to live condition", v, 16'h0008);
    for (int i = 0; i < 4; i++) begin
      rreg(3'd0, v); chk("R4 receive order", v, 16'h00A0 + 16'(i));
    end
    wreg(3'd4, 16'h0008);
    settle();
    rreg(3'd4, v); chk("R9 cleared by write one", v, 16'h0000);
    wreg(3'd5, 16'h2000);
    settle();
    chk("R10 irq idle while enabled event clear", 16'(irq), 16'h0000);
    rxpush(8'hB0); rxpush(8'hB1);
    settle();
    rreg(3'd4, v); chk("R7 receive drain on short remainder", v, 16'h2000);
    rreg(3'd3, v); chk("R7 remainder count in status", v, 16'h4002);
    chk("R10 irq on enabled drain", 16'(irq), 16'h0001);
    wreg(3'd5, 16'h0000);
    settle();
    chk("R10 irq drops when enable cleared", 16'(irq), 16'h0000);
    wreg(3'd2, 16'h4000);
    settle();
    rreg(3'd3, v); chk("R3 receive clear empties fifo", v, 16'h4000);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    xfer_rx = 1'b1;
    wreg(3'd2, 16'h4040);
    wreg(3'd1, 16'd40);
    wreg(3'd4, 16'hFFFF);
    for (int i = 0; i < 17; i++) rxpush(8'h10 + 8'(i));
    settle();
    rreg(3'd4, v); chk("R11 overrun flag", v & 16'h0800, 16'h0800);
    rreg(3'd3, v); chk("R11 level stays at depth", v, 16'h4010);
    rreg(3'd0, v); chk("R11 oldest byte kept", v, 16'h0010);
    wreg(3'd2, 16'h4040);
  endtask

  task automatic t_tx();
    logic [15:0] v;
    logic [7:0]  b;
    xfer_rx = 1'b0;
    wreg(3'd2, 16'h4043);
    wreg(3'd1, 16'd6);
    wreg(3'd4, 16'hFFFF);
    settle();
    rreg(3'd4, v); chk("R6 transmit ready with room and demand", v, 16'h0010);
    wreg(3'd0, 16'h0011); wreg(3'd0, 16'h0022);
    wreg(3'd0, 16'h0033); wreg(3'd0, 16'h0044);
    settle();
    rreg(3'd4, v); chk("R8 transmit drain on short need", v, 16'h4010);
    rreg(3'd3, v); chk("R8 need count in status", v, 16'h4002);
    txpop(b); chk("R4 first byte to engine", 16'(b), 16'h0011);
    txpop(b); chk("R4 second byte to engine", 16'(b), 16'h0022);
    rreg(3'd1, v); chk("R13 count after two pops", v, 16'd4);
    wreg(3'd2, 16'h0043);
    settle();
    rreg(3'd3, v); chk("R3 transmit clear raises need", v, 16'h4004);
  endtask

  task automatic t_underflow();
    logic [15:0] v;
    logic [7:0]  b;
    xfer_rx = 1'b0;
    wreg(3'd2, 16'h4040);
    wreg(3'd1, 16'd0);
    wreg(3'd4, 16'hFFFF);
    txpop(b); chk("R12 empty pop returns zero", 16'(b), 16'h0000);
    settle();
    rreg(3'd4, v); chk("R12 underflow flag", v, 16'h0400);
    rreg(3'd1, v); chk("R13 count holds at zero", v, 16'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx();
    t_overrun();
    t_tx();
    t_underflow();
    finish_run();
  end
endmodule